// File: doc/BRIEF.md
# Four-Voice Wavetable Mixer with Legacy Sample Shadowing

This block is the datapath of a sound coprocessor. Four wavetable voices each step a 16-bit phase accumulator on every sample tick. The top six phase bits pick one of 64 waveform points. Each voice scales its point by its own volume. The voices are summed in an 11-bit accumulator, divided by the voice count and clamped to an 8-bit output sample. The tick comes from outside, so the output rate is set by whatever the system drives there, for example 7.8 kHz or 15 kHz.

Waveform points normally come from four built-in 8-bit waveforms, chosen by a select input. The block also watches the main memory bus. Any write that lands in a 64-byte legacy sample window is copied into a 6-bit shadow table. The first such write also switches the mixer into fall-back mode. In that mode every voice reads the shadow table, and each 6-bit value is widened to 8 bits by appending two zero bits. Fall-back mode is left only through reset or a software clear.

Top module: `wavemix`

## Requirements
- R1: After reset, the audio output is 0, fall-back mode is off, every phase accumulator is 0 and every shadow entry is 0.
- R2: Phase accumulators and the audio output change only on a clock edge where `tick` is 1. On that edge each phase becomes phase + increment (mod 2^16), and the audio output takes the mix computed from the new phases.
- R3: With fall-back off, the point at index i (phase bits 15:10) of waveform `pal_sel` is: 0 → i*4; 1 → 255 if i ≥ 32, else 0; 2 → i*8 for i < 32, (63 − i)*8 for i ≥ 32; 3 → 255 − i*4.
- R4: Each voice contributes floor(point × volume / 16), where volume is a 5-bit unsigned value and 16 is unity gain. The output is floor(sum / 4), clamped to 255.
- R5: A bus write with an address inside 0x0600–0x063F turns fall-back mode on, and the mode then stays on. A write outside that window changes neither the mode nor the output.
- R6: With fall-back on, the point at index i is the low 6 bits of the last byte written to address 0x0600 + i, shifted left by two.
- R7: `fb_clear` turns fall-back mode off on the next edge. If a window write happens on the same edge, the write wins and the mode stays on.
- R8: The shadow table records every window write, whatever the mode. Entries written before a clear are still used when fall-back is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_we | input | 1 | Write strobe seen on the memory bus |
| snoop_addr | input | 16 | Address of the snooped write |
| snoop_data | input | 8 | Data of the snooped write |
| fb_clear | input | 1 | Software clear of fall-back mode |
| pal_sel | input | 2 | Built-in waveform select |
| tick | input | 1 | Sample-rate strobe, one clock wide |
| phase_inc | input | 64 | Per-voice phase increments, voice c in bits 16c+15:16c |
| volume | input | 20 | Per-voice volumes, voice c in bits 5c+4:5c |
| audio_out | output | 8 | Mixed audio sample |
| fallback | output | 1 | Fall-back mode is active |

## Verification
On every cycle the assertions check that the output and voice 0's phase hold still between ticks, and that voice 0 steps by exactly its increment on a tick. They also check the fall-back mode rules: a window write sets the mode, the mode stays set until a clear, and a clear without a window write resets it. The sample values themselves can only be shown by the bench's scenarios. These cover each built-in waveform under mixed increments and volumes, clamping at full volume, the shadowed values after the switch into fall-back, and reuse of old shadow entries after a clear and re-entry.

// File: rtl/wavemix.sv
module wavemix #(
  parameter int NCH = 4,
  parameter int PHW = 16,
  parameter int IDXW = 6,
  parameter int SW = 6,
  parameter int OW = 8,
  parameter int VW = 5,
  parameter int PSW = 2,
  parameter int AW = 16,
  parameter logic [AW-1:0] WIN_BASE = 16'h0600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snoop_we,
  input  logic [AW-1:0]      snoop_addr,
  input  logic [OW-1:0]      snoop_data,
  input  logic               fb_clear,
  input  logic [PSW-1:0]     pal_sel,
  input  logic               tick,
  input  logic [NCH*PHW-1:0] phase_inc,
  input  logic [NCH*VW-1:0]  volume,
  output logic [OW-1:0]      audio_out,
  output logic               fallback
);
  localparam int DEPTH = 1 << IDXW;
  localparam int SH    = $clog2(NCH);
  localparam int CW    = OW + VW - 4;
  localparam int ACCW  = CW + SH;
  localparam logic [ACCW-1:0] OMAX = ACCW'((1 << OW) - 1);

  logic [PHW-1:0]  phase [NCH];
  logic [PHW-1:0]  nph   [NCH];
  logic [SW-1:0]   shadow [DEPTH];
  logic [ACCW-1:0] acc;
  logic [ACCW-1:0] scaled;
  logic [OW-1:0]   mix;

  wire in_win = snoop_we && (snoop_addr[AW-1:IDXW] == WIN_BASE[AW-1:IDXW]);
  wire [OW-SW-1:0] unused_hi = snoop_data[OW-1:SW];

  function automatic logic [OW-1:0] builtin(input logic [PSW-1:0] sel, input logic [IDXW-1:0] i);
    case (sel)
      2'd1:    builtin = {OW{i[IDXW-1]}};
      2'd2:    builtin = i[IDXW-1] ? OW'({~i[IDXW-2:0], {(OW-IDXW+1){1'b0}}})
                                   : OW'({ i[IDXW-2:0], {(OW-IDXW+1){1'b0}}});
      2'd3:    builtin = ~OW'({i, {(OW-IDXW){1'b0}}});
      default: builtin = OW'({i, {(OW-IDXW){1'b0}}});
    endcase
  endfunction

  always_comb begin
    acc = '0;
    for (int c = 0; c < NCH; c++) begin
      logic [IDXW-1:0] ix;
      logic [OW-1:0]   s;
      nph[c] = phase[c] + phase_inc[c*PHW +: PHW];
      ix = nph[c][PHW-1 -: IDXW];
      s = fallback ? {shadow[ix], {(OW-SW){1'b0}}} : builtin(pal_sel, ix);
      acc = acc + ACCW'(CW'(({{VW{1'b0}}, s} * {{OW{1'b0}}, volume[c*VW +: VW]}) >> 4));
    end
    scaled = acc >> SH;
    mix = (scaled > OMAX) ? OMAX[OW-1:0] : scaled[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      audio_out <= '0;
      fallback  <= 1'b0;
      for (int c = 0; c < NCH; c++) phase[c] <= '0;
      for (int k = 0; k < DEPTH; k++) shadow[k] <= '0;
    end else begin
      if (tick) begin
        audio_out <= mix;
        for (int c = 0; c < NCH; c++) phase[c] <= nph[c];
      end
      if (in_win) begin
        fallback <= 1'b1;
        shadow[snoop_addr[IDXW-1:0]] <= snoop_data[SW-1:0];
      end else if (fb_clear) begin
        fallback <= 1'b0;
      end
    end
  end
endmodule

module wavemix_chk #(
  parameter int AW = 16,
  parameter int IDXW = 6,
  parameter int PHW = 16,
  parameter logic [AW-1:0] WIN_BASE = 16'h0600
) (
  input logic           clk,
  input logic           rst_n,
  input logic           snoop_we,
  input logic [AW-1:0]  snoop_addr,
  input logic           fb_clear,
  input logic           tick,
  input logic [7:0]     audio_out,
  input logic           fallback,
  input logic [PHW-1:0] ph0,
  input logic [PHW-1:0] inc0
);
  wire hit = snoop_we && (snoop_addr >= WIN_BASE) && (snoop_addr < WIN_BASE + AW'(1 << IDXW));

  a_r2_hold_audio: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(audio_out));
  a_r2_hold_phase: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(ph0));
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n) tick |=> ph0 == PHW'($past(ph0) + $past(inc0)));
  a_r5_set:        assert property (@(posedge clk) disable iff (!rst_n) hit |=> fallback);
  a_r5_sticky:     assert property (@(posedge clk) disable iff (!rst_n) fallback && !fb_clear |=> fallback);
  a_r7_clear:      assert property (@(posedge clk) disable iff (!rst_n) fb_clear && !hit |=> !fallback);
endmodule

bind wavemix wavemix_chk #(.AW(AW), .IDXW(IDXW), .PHW(PHW), .WIN_BASE(WIN_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
  .fb_clear(fb_clear), .tick(tick), .audio_out(audio_out), .fallback(fallback),
  .ph0(phase[0]), .inc0(phase_inc[PHW-1:0])
);

// File: tb/wavemix_tb_top.sv
module wavemix_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        snoop_we = 1'b0;
  logic [15:0] snoop_addr = '0;
  logic [7:0]  snoop_data = '0;
  logic        fb_clear = 1'b0;
  logic [1:0]  pal_sel = '0;
  logic        tick = 1'b0;
  logic [63:0] phase_inc = '0;
  logic [19:0] volume = '0;
  logic [7:0]  audio_out;
  logic        fallback;

  wavemix dut_i (
    .clk(clk), .rst_n(rst_n), .snoop_we(snoop_we), .snoop_addr(snoop_addr),
    .snoop_data(snoop_data), .fb_clear(fb_clear), .pal_sel(pal_sel), .tick(tick),
    .phase_inc(phase_inc), .volume(volume), .audio_out(audio_out), .fallback(fallback)
  );

  int errs = 0, checks = 0;
  int mph [4];
  int msh [64];
  bit mfb = 0;
  int last_exp = 0;
  bit done = 0;
  int   exp_q [$];
  string tag_q [$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int palv(int sel, int i);
    case (sel)
      1: return (i >= 32) ? 255 : 0;
      2: return (i < 32) ? i * 8 : (63 - i) * 8;
      3: return 255 - i * 4;
      default: return i * 4;
    endcase
  endfunction

  function automatic int model_mix();
    int sum = 0;
    for (int c = 0; c < 4; c++) begin
      int p = (mph[c] + int'(phase_inc[c*16 +: 16])) & 16'hffff;
      int i = p >> 10;
      int s = mfb ? msh[i] * 4 : palv(int'(pal_sel), i);
      sum += (s * int'(volume[c*5 +: 5])) / 16;
    end
    sum = sum / 4;
    return (sum > 255) ? 255 : sum;
  endfunction

  task automatic do_tick(string tag);
    @(negedge clk);
    last_exp = model_mix();
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    for (int c = 0; c < 4; c++) mph[c] = (mph[c] + int'(phase_inc[c*16 +: 16])) & 16'hffff;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic snoop(int a, int d, bit clr);
    @(negedge clk);
    snoop_we = 1'b1; snoop_addr = 16'(a); snoop_data = 8'(d); fb_clear = clr;
    @(negedge clk);
    snoop_we = 1'b0; fb_clear = 1'b0;
    if (a >= 16'h0600 && a < 16'h0640) begin
      msh[a - 16'h0600] = d & 63;
      mfb = 1;
    end else if (clr) mfb = 0;
  endtask

  task automatic clear_fb();
    @(negedge clk);
    fb_clear = 1'b1;
    @(negedge clk);
    fb_clear = 1'b0;
    mfb = 0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk iff tick);
      @(negedge clk);
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), int'(audio_out), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : driver
    for (int c = 0; c < 4; c++) mph[c] = 0;
    for (int k = 0; k < 64; k++) msh[k] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 audio after reset", int'(audio_out), 0);
    check("R1 fallback after reset", int'(fallback), 0);

    // R3 / R4: single voice, each waveform
    volume = {5'd0, 5'd0, 5'd0, 5'd16};
    phase_inc[15:0] = 16'h0400;
    for (int s = 0; s < 4; s++) begin
      pal_sel = 2'(s);
      for (int n = 0; n < 20; n++) do_tick("R3 single voice waveform");
    end

    // R2: output holds with no tick
    repeat (6) @(negedge clk);
    check("R2 audio holds without tick", int'(audio_out), last_exp);

    // R3 / R4: four voices, mixed increments and volumes
    phase_inc = {16'h1234, 16'h0A00, 16'h0330, 16'hF100};
    volume = {5'd31, 5'd8, 5'd20, 5'd12};
    for (int s = 0; s < 4; s++) begin
      pal_sel = 2'(s);
      for (int n = 0; n < 25; n++) do_tick("R4 four voice mix");
    end

    // R4: saturation at full volume on the square wave
    pal_sel = 2'd1;
    volume = {4{5'd31}};
    phase_inc = '0;
    for (int c = 0; c < 4; c++) mph[c] = mph[c];
    do_tick("R4 hold phases");
    phase_inc = {4{16'h0400}};
    for (int n = 0; n < 70; n++) do_tick("R4 saturating mix");
    begin
      bit seen = 0;
      for (int n = 0; n < 64 && !seen; n++) begin
        do_tick("R4 clamp search");
        if (last_exp == 255) seen = 1;
      end
      @(negedge clk);
      if (seen) check("R4 clamp to 255", int'(audio_out), 255);
    end

    // R5: outside-window writes ignored
    volume = {5'd16, 5'd16, 5'd16, 5'd16};
    phase_inc = {16'h0800, 16'h0C00, 16'h0400, 16'h1000};
    pal_sel = 2'd2;
    snoop(16'h05FF, 8'h3F, 0);
    snoop(16'h0640, 8'h15, 0);
    check("R5 fallback after outside writes", int'(fallback), 0);
    for (int n = 0; n < 10; n++) do_tick("R5 outside writes leave mix");

    // R5 / R6: fill window, enter fall-back
    for (int k = 0; k < 64; k++) snoop(16'h0600 + k, (k * 37 + 200) & 255, 0);
    check("R5 fallback set by window write", int'(fallback), 1);
    for (int n = 0; n < 30; n++) do_tick("R6 shadow samples");
    pal_sel = 2'd0;
    for (int n = 0; n < 10; n++) do_tick("R6 waveform select ignored in fallback");

    // R7: clear, then simultaneous clear and write
    clear_fb();
    check("R7 clear drops fallback", int'(fallback), 0);
    for (int n = 0; n < 10; n++) do_tick("R7 built-in after clear");
    snoop(16'h0605, 8'h2A, 1);
    check("R7 write wins over clear", int'(fallback), 1);

    // R8: writes while cleared are kept; old entries reused
    clear_fb();
    snoop(16'h0611, 8'h07, 0);
    check("R8 fallback on after re-entry", int'(fallback), 1);
    for (int n = 0; n < 40; n++) do_tick("R8 old and new shadow entries");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule